// File: doc/BRIEF.md
# Generation-Tagged Flow Cache Lookup

This block resolves a parsed flow key into either an action or an exception. A request carries the key, the packet length and a hardware timestamp. The key is hashed with a Toeplitz hash over a programmable secret. The low hash bits then index a small direct-mapped first-level table, backed by a larger direct-mapped second-level table. Both levels compare the full key. When a lookup hits a current entry, the block returns that entry's action word and updates its byte count, packet count and last-seen timestamp. When no entry matches, the result is an exception, and the packet goes to host software.

Policy changes are handled lazily. A pulse on the policy-update input advances a global generation counter. Every entry remembers the generation that was current when software installed it. An entry whose stored generation no longer matches still matches on key, but it is reported as a stale exception, so software can reinstall it with fresh policy. Software installs entries through a single-cycle write port. Only one lookup is processed at a time.

Top module: `flow_gen_lookup`

## Requirements
- R1: `res_hash` equals the Toeplitz hash of the key. Secret bits are numbered from the secret's MSB (position 0 is `hash_secret[134]`). For each key bit set at MSB-first position i (position 0 is key bit 103), the 32 secret bits at positions i to i+31 are XORed into the hash. Secret position i lands on hash bit 31.
- R2: The first-level slot is hash bits [3:0] and the second-level slot is hash bits [7:0]. An entry answers only when its whole 104-bit key equals the request key.
- R3: A key found in neither level gives an exception with `res_exc`=1 and `res_stale`=0. The action, byte, packet and timestamp outputs are then all zero.
- R4: A first-level match presents its result one clock edge after the request is accepted, with `res_l1`=1. A second-level match or a miss takes two edges, with `res_l1`=0.
- R5: A second-level match copies the entry into its first-level slot, evicting the previous occupant, so the next lookup of that key answers from the first level.
- R6: The generation counter (8 bits, reset 0) steps by one on each policy pulse and wraps modulo 256.
- R7: A match whose stored generation differs from the current one gives `res_exc`=1 and `res_stale`=1. Its counters and timestamp are left unchanged. Once the counter wraps back to the stored value, the entry hits normally again.
- R8: A current match adds the packet length to the byte count and one to the packet count. The result reports the totals after this update.
- R9: `res_prev_ts` of a current match is the timestamp recorded by the previous hit of that entry, or zero after install. The hit then records the request's timestamp.
- R10: An install writes the key and action into both levels at the key's slots, replacing any occupant. It zeroes the counters and timestamp and stamps the generation value held in that cycle, so a policy pulse in the same cycle leaves the new entry stale.
- R11: `req_ready` is high only while idle and no result is pending. A presented result holds steady until `res_ready` completes the handshake.
- R12: An install landing in the same cycle as a hit's counter update to the same entry wins, so the entry holds the freshly installed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_secret | input | 135 | Toeplitz secret |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a request |
| req_key | input | 104 | Flow key |
| req_len | input | 16 | Packet length in bytes |
| req_ts | input | 32 | Packet timestamp |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_exc | output | 1 | Exception: send to software |
| res_stale | output | 1 | Exception caused by an outdated generation |
| res_l1 | output | 1 | Answered by the first level |
| res_action | output | 24 | Stored action parameters |
| res_bytes | output | 40 | Byte total after update |
| res_pkts | output | 32 | Packet total after update |
| res_prev_ts | output | 32 | Timestamp of previous hit |
| res_hash | output | 32 | Hash of the key |
| wr_en | input | 1 | Install strobe |
| wr_key | input | 104 | Key to install |
| wr_action | input | 24 | Action parameters to install |
| policy_pulse | input | 1 | Advance the generation |

## Verification
A first-level answer, including a stale one, is due one rising edge after the accepting edge. Second-level answers and misses are due two edges after it. The bench counts rising edges from acceptance up to the first falling edge at which `res_valid` is seen, and compares that count with the expected level. All outputs are sampled on falling edges. An install meant to collide with a hit is raised right after the accepting edge, so it lands on the edge that resolves the lookup. Its effect is then read back through the following lookup.

// File: rtl/flow_gen_lookup.sv
module flow_gen_lookup #(
  parameter int KEY_W    = 104,
  parameter int HASH_W   = 32,
  parameter int L1_DEPTH = 16,
  parameter int L2_DEPTH = 256,
  parameter int ACT_W    = 24,
  parameter int LEN_W    = 16,
  parameter int TS_W     = 32,
  parameter int BYTE_W   = 40,
  parameter int PKT_W    = 32,
  parameter int GEN_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [KEY_W+HASH_W-2:0]   hash_secret,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [KEY_W-1:0]          req_key,
  input  logic [LEN_W-1:0]          req_len,
  input  logic [TS_W-1:0]           req_ts,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic                      res_exc,
  output logic                      res_stale,
  output logic                      res_l1,
  output logic [ACT_W-1:0]          res_action,
  output logic [BYTE_W-1:0]         res_bytes,
  output logic [PKT_W-1:0]          res_pkts,
  output logic [TS_W-1:0]           res_prev_ts,
  output logic [HASH_W-1:0]         res_hash,
  input  logic                      wr_en,
  input  logic [KEY_W-1:0]          wr_key,
  input  logic [ACT_W-1:0]          wr_action,
  input  logic                      policy_pulse
);
  localparam int SEC_W = KEY_W + HASH_W - 1;
  localparam int L1_IW = $clog2(L1_DEPTH);
  localparam int L2_IW = $clog2(L2_DEPTH);

  function automatic logic [HASH_W-1:0] toeplitz(input logic [KEY_W-1:0] k,
                                                 input logic [SEC_W-1:0] s);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int i = 0; i < KEY_W; i++)
      if (k[KEY_W-1-i]) h ^= s[SEC_W-1-i -: HASH_W];
    return h;
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_RESP} st_t;
  st_t st;

  logic [KEY_W-1:0]  cur_key;
  logic [LEN_W-1:0]  cur_len;
  logic [TS_W-1:0]   cur_ts;
  logic [HASH_W-1:0] cur_hash;
  logic [GEN_W-1:0]  gen_q;

  logic              l1_v   [L1_DEPTH];
  logic [KEY_W-1:0]  l1_key [L1_DEPTH];
  logic [ACT_W-1:0]  l1_act [L1_DEPTH];
  logic [GEN_W-1:0]  l1_gen [L1_DEPTH];
  logic [BYTE_W-1:0] l1_byt [L1_DEPTH];
  logic [PKT_W-1:0]  l1_pkt [L1_DEPTH];
  logic [TS_W-1:0]   l1_ts  [L1_DEPTH];

  logic              l2_v   [L2_DEPTH];
  logic [KEY_W-1:0]  l2_key [L2_DEPTH];
  logic [ACT_W-1:0]  l2_act [L2_DEPTH];
  logic [GEN_W-1:0]  l2_gen [L2_DEPTH];
  logic [BYTE_W-1:0] l2_byt [L2_DEPTH];
  logic [PKT_W-1:0]  l2_pkt [L2_DEPTH];
  logic [TS_W-1:0]   l2_ts  [L2_DEPTH];

  logic [L1_IW-1:0] i1, wi1;
  logic [L2_IW-1:0] i2, wi2;
  logic hit1, hit2, src_hit, fresh, upd, resolve;
  logic [ACT_W-1:0]  src_act;
  logic [GEN_W-1:0]  src_gen;
  logic [BYTE_W-1:0] src_byt, new_byt;
  logic [PKT_W-1:0]  src_pkt, new_pkt;
  logic [TS_W-1:0]   src_ts;

  assign i1 = cur_hash[L1_IW-1:0];
  assign i2 = cur_hash[L2_IW-1:0];
  always_comb begin
    wi2 = L2_IW'(toeplitz(wr_key, hash_secret));
    wi1 = L1_IW'(wi2);
  end

  assign hit1 = l1_v[i1] && (l1_key[i1] == cur_key);
  assign hit2 = l2_v[i2] && (l2_key[i2] == cur_key);

  assign src_hit = (st == S_L1) ? hit1       : hit2;
  assign src_act = (st == S_L1) ? l1_act[i1] : l2_act[i2];
  assign src_gen = (st == S_L1) ? l1_gen[i1] : l2_gen[i2];
  assign src_byt = (st == S_L1) ? l1_byt[i1] : l2_byt[i2];
  assign src_pkt = (st == S_L1) ? l1_pkt[i1] : l2_pkt[i2];
  assign src_ts  = (st == S_L1) ? l1_ts[i1]  : l2_ts[i2];

  assign resolve = (st == S_L1 && hit1) || (st == S_L2);
  assign fresh   = src_hit && (src_gen == gen_q);
  assign upd     = resolve && fresh;
  assign new_byt = src_byt + BYTE_W'(cur_len);
  assign new_pkt = src_pkt + PKT_W'(1);

  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_RESP);
  assign res_hash  = cur_hash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) st <= S_L1;
        S_L1:   st <= hit1 ? S_RESP : S_L2;
        S_L2:   st <= S_RESP;
        S_RESP: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gen_q <= '0;
    else if (policy_pulse) gen_q <= gen_q + GEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && req_valid) begin
      cur_key  <= req_key;
      cur_len  <= req_len;
      cur_ts   <= req_ts;
      cur_hash <= toeplitz(req_key, hash_secret);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_exc     <= 1'b0;
      res_stale   <= 1'b0;
      res_l1      <= 1'b0;
      res_action  <= '0;
      res_bytes   <= '0;
      res_pkts    <= '0;
      res_prev_ts <= '0;
    end else if (resolve) begin
      res_exc     <= !fresh;
      res_stale   <= src_hit && !fresh;
      res_l1      <= (st == S_L1);
      res_action  <= fresh ? src_act : '0;
      res_bytes   <= fresh ? new_byt : '0;
      res_pkts    <= fresh ? new_pkt : '0;
      res_prev_ts <= fresh ? src_ts  : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < L1_DEPTH; n++) l1_v[n] <= 1'b0;
      for (int n = 0; n < L2_DEPTH; n++) l2_v[n] <= 1'b0;
    end else begin
      if (st == S_L2 && hit2) l1_v[i1] <= 1'b1;
      if (wr_en) begin
        l1_v[wi1] <= 1'b1;
        l2_v[wi2] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_L2 && hit2) begin
      l1_key[i1] <= cur_key;
      l1_act[i1] <= l2_act[i2];
      l1_gen[i1] <= l2_gen[i2];
      l1_byt[i1] <= l2_byt[i2];
      l1_pkt[i1] <= l2_pkt[i2];
      l1_ts[i1]  <= l2_ts[i2];
    end
    if (upd) begin
      l1_byt[i1] <= new_byt;
      l1_pkt[i1] <= new_pkt;
      l1_ts[i1]  <= cur_ts;
      l2_byt[i2] <= new_byt;
      l2_pkt[i2] <= new_pkt;
      l2_ts[i2]  <= cur_ts;
    end
    if (wr_en) begin
      l1_key[wi1] <= wr_key;
      l1_act[wi1] <= wr_action;
      l1_gen[wi1] <= gen_q;
      l1_byt[wi1] <= '0;
      l1_pkt[wi1] <= '0;
      l1_ts[wi1]  <= '0;
      l2_key[wi2] <= wr_key;
      l2_act[wi2] <= wr_action;
      l2_gen[wi2] <= gen_q;
      l2_byt[wi2] <= '0;
      l2_pkt[wi2] <= '0;
      l2_ts[wi2]  <= '0;
    end
  end
endmodule

// File: rtl/flow_gen_lookup_chk.sv
module flow_gen_lookup_chk #(
  parameter int ACT_W  = 24,
  parameter int BYTE_W = 40,
  parameter int PKT_W  = 32,
  parameter int GEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_exc,
  input logic              res_stale,
  input logic [ACT_W-1:0]  res_action,
  input logic [BYTE_W-1:0] res_bytes,
  input logic [PKT_W-1:0]  res_pkts,
  input logic              policy_pulse,
  input logic [GEN_W-1:0]  gen_q
);
  assert_one_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  assert_accept_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_exc) && $stable(res_pkts)
                                   && $stable(res_bytes) && $stable(res_action)));

  assert_gen_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    policy_pulse |=> (gen_q == $past(gen_q) + GEN_W'(1)));

  assert_gen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !policy_pulse |=> $stable(gen_q));

  assert_stale_is_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_stale) |-> res_exc);

  assert_exc_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_exc) |-> (res_action == '0 && res_pkts == '0 && res_bytes == '0));

  assert_hit_counted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_exc) |-> (res_pkts != '0));
endmodule

bind flow_gen_lookup flow_gen_lookup_chk #(
  .ACT_W(ACT_W), .BYTE_W(BYTE_W), .PKT_W(PKT_W), .GEN_W(GEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_exc(res_exc),
  .res_stale(res_stale), .res_action(res_action), .res_bytes(res_bytes),
  .res_pkts(res_pkts), .policy_pulse(policy_pulse), .gen_q(gen_q)
);

// File: tb/sim_flow_gen_lookup.sv
`timescale 1ns/1ps
module sim_flow_gen_lookup;
  localparam int KEY_W = 104, HASH_W = 32, SEC_W = KEY_W + HASH_W - 1;
  localparam int ACT_W = 24;
  localparam logic [SEC_W-1:0] SECRET =
    {3'b101, 128'h6d5a56da255b0ec24167253d43a38fb0, 4'hd};

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, res_ready = 1, wr_en = 0, policy_pulse = 0;
  logic [KEY_W-1:0] req_key = '0, wr_key = '0;
  logic [15:0] req_len = '0;
  logic [31:0] req_ts = '0;
  logic [ACT_W-1:0] wr_action = '0;
  logic req_ready, res_valid, res_exc, res_stale, res_l1;
  logic [ACT_W-1:0] res_action;
  logic [39:0] res_bytes;
  logic [31:0] res_pkts, res_prev_ts, res_hash;

  flow_gen_lookup u0 (
    .clk(clk), .rst_n(rst_n), .hash_secret(SECRET),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
    .req_len(req_len), .req_ts(req_ts),
    .res_valid(res_valid), .res_ready(res_ready), .res_exc(res_exc),
    .res_stale(res_stale), .res_l1(res_l1), .res_action(res_action),
    .res_bytes(res_bytes), .res_pkts(res_pkts), .res_prev_ts(res_prev_ts),
    .res_hash(res_hash), .wr_en(wr_en), .wr_key(wr_key),
    .wr_action(wr_action), .policy_pulse(policy_pulse)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int r_lat;
  logic r_exc, r_stale, r_l1;
  logic [ACT_W-1:0] r_act;
  logic [39:0] r_byt;
  logic [31:0] r_pkt, r_pts, r_hash;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [HASH_W-1:0] ref_hash(input logic [KEY_W-1:0] k);
    logic [HASH_W-1:0] h = '0;
    for (int j = 0; j < HASH_W; j++)
      for (int i = 0; i < KEY_W; i++)
        if (k[KEY_W-1-i] && SECRET[SEC_W-1-i-j]) h[HASH_W-1-j] = ~h[HASH_W-1-j];
    return h;
  endfunction

  task automatic install(input logic [KEY_W-1:0] k, input logic [ACT_W-1:0] a, input bit pulse);
    @(negedge clk);
    wr_en = 1; wr_key = k; wr_action = a; policy_pulse = pulse;
    @(negedge clk);
    wr_en = 0; policy_pulse = 0;
  endtask

  task automatic pulses(input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); policy_pulse = 1;
      @(negedge clk); policy_pulse = 0;
    end
  endtask

  task automatic lookup(input logic [KEY_W-1:0] k, input int len, input int ts,
                        input bit ins_mid, input logic [ACT_W-1:0] ins_act, input int hold);
    @(negedge clk);
    res_ready = (hold == 0);
    req_valid = 1; req_key = k; req_len = 16'(len); req_ts = 32'(ts);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (ins_mid) begin wr_en = 1; wr_key = k; wr_action = ins_act; end
    r_lat = 0;
    while (!res_valid) begin
      @(posedge clk); r_lat++;
      @(negedge clk); wr_en = 0;
    end
    wr_en = 0;
    r_exc = res_exc; r_stale = res_stale; r_l1 = res_l1; r_act = res_action;
    r_byt = res_bytes; r_pkt = res_pkts; r_pts = res_prev_ts; r_hash = res_hash;
    for (int c = 0; c < hold; c++) begin
      @(posedge clk); @(negedge clk);
      chk("R11 result held valid", 64'(res_valid), 64'd1);
      chk("R11 result held pkts", 64'(res_pkts), 64'(r_pkt));
      chk("R11 ready low while pending", 64'(req_ready), 64'd0);
    end
    res_ready = 1;
    @(posedge clk);
  endtask

  task automatic expect_hit(input string tag, input int lat, input logic [ACT_W-1:0] a,
                            input longint byt, input longint pkt, input longint pts);
    chk({tag, " R4 latency"}, 64'(r_lat), 64'(lat));
    chk({tag, " R4 level"}, 64'(r_l1), (lat == 1) ? 64'd1 : 64'd0);
    chk({tag, " exc"}, 64'(r_exc), 64'd0);
    chk({tag, " R8 action"}, 64'(r_act), 64'(a));
    chk({tag, " R8 bytes"}, 64'(r_byt), 64'(byt));
    chk({tag, " R8 pkts"}, 64'(r_pkt), 64'(pkt));
    chk({tag, " R9 prev ts"}, 64'(r_pts), 64'(pts));
  endtask

  task automatic expect_exc(input string tag, input int lat, input bit stale);
    chk({tag, " R4 latency"}, 64'(r_lat), 64'(lat));
    chk({tag, " R3 exc"}, 64'(r_exc), 64'd1);
    chk({tag, " R7 stale flag"}, 64'(r_stale), 64'(stale));
    chk({tag, " R3 action zero"}, 64'(r_act), 64'd0);
    chk({tag, " R3 pkts zero"}, 64'(r_pkt), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [KEY_W-1:0] kA, kB, kC, k;
    logic [HASH_W-1:0] hA, h;
    bit gotB, gotC;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset ready", 64'(req_ready), 64'd1);
    chk("R11 reset no result", 64'(res_valid), 64'd0);

    // R1 single-bit keys and a sweep; table empty so every lookup misses (R3)
    lookup({1'b1, {(KEY_W-1){1'b0}}}, 1, 1, 0, '0, 0);
    chk("R1 msb key hash", 64'(r_hash), 64'(SECRET[SEC_W-1 -: HASH_W]));
    lookup({{(KEY_W-1){1'b0}}, 1'b1}, 1, 1, 0, '0, 0);
    chk("R1 lsb key hash", 64'(r_hash), 64'(SECRET[HASH_W-1:0]));
    for (int n = 1; n <= 12; n++) begin
      k = {32'(n * 32'h9e3779b9), 32'(n * 32'h85ebca6b), 40'(n * 40'h00c2b2ae35)};
      lookup(k, 64, n, 0, '0, 0);
      chk("R1 sweep hash", 64'(r_hash), 64'(ref_hash(k)));
      expect_exc("R3 empty miss", 2, 0);
    end

    kA = 104'h0a000001_0a000002_1f90_0050_06;
    hA = ref_hash(kA);
    gotB = 0; gotC = 0; kB = '0; kC = '0;
    for (int n = 1; n < 6000 && !(gotB && gotC); n++) begin
      k = kA ^ (104'(n) << 16);
      h = ref_hash(k);
      if (!gotB && h[3:0] == hA[3:0] && h[7:0] != hA[7:0]) begin kB = k; gotB = 1; end
      if (!gotC && h[7:0] == hA[7:0]) begin kC = k; gotC = 1; end
    end
    chk("R2 search found keys", 64'({gotB, gotC}), 64'd3);

    install(kA, 24'h0000a1, 0);
    lookup(kA, 100, 1000, 0, '0, 0);
    expect_hit("R10 first hit", 1, 24'h0000a1, 100, 1, 0);
    lookup(kA, 60, 2000, 0, '0, 0);
    expect_hit("R8 second hit", 1, 24'h0000a1, 160, 2, 1000);

    install(kB, 24'h0000b2, 0);
    lookup(kA, 40, 3000, 0, '0, 0);
    expect_hit("R5 level2 hit", 2, 24'h0000a1, 200, 3, 2000);
    lookup(kA, 10, 4000, 0, '0, 0);
    expect_hit("R5 refilled level1", 1, 24'h0000a1, 210, 4, 3000);
    lookup(kB, 7, 5000, 0, '0, 0);
    expect_hit("R5 evicted key level2", 2, 24'h0000b2, 7, 1, 0);

    install(kC, 24'h0000c3, 0);
    lookup(kA, 1, 1, 0, '0, 0);
    expect_exc("R2 full key compare", 2, 0);
    lookup(kC, 8, 6000, 0, '0, 0);
    expect_hit("R2 replacing key", 1, 24'h0000c3, 8, 1, 0);

    install(kA, 24'h0000a4, 0);
    lookup(kA, 50, 7000, 0, '0, 0);
    expect_hit("R10 reinstall zeroes", 1, 24'h0000a4, 50, 1, 0);

    pulses(1);
    lookup(kA, 20, 8000, 0, '0, 0);
    expect_exc("R7 stale after pulse", 1, 1);
    chk("R7 stale answered level1", 64'(r_l1), 64'd1);
    lookup(kA, 30, 9000, 0, '0, 3);
    expect_exc("R11 stale backpressured", 1, 1);
    pulses(255);
    lookup(kA, 70, 10000, 0, '0, 0);
    expect_hit("R6 R7 wrap fresh", 1, 24'h0000a4, 120, 2, 7000);

    pulses(1);
    install(kA, 24'h0000a5, 0);
    lookup(kA, 5, 11000, 0, '0, 0);
    expect_hit("R10 stamps current gen", 1, 24'h0000a5, 5, 1, 0);

    install(kB, 24'h0000b6, 1);
    lookup(kB, 9, 1, 0, '0, 0);
    expect_exc("R10 same cycle pulse stale", 1, 1);

    install(kA, 24'h0000a7, 0);
    lookup(kA, 3, 12000, 0, '0, 0);
    expect_hit("R12 setup", 1, 24'h0000a7, 3, 1, 0);
    lookup(kA, 4, 13000, 1, 24'h0000a8, 0);
    expect_hit("R12 colliding hit", 1, 24'h0000a7, 7, 2, 12000);
    lookup(kA, 6, 14000, 0, '0, 0);
    expect_hit("R12 install won", 1, 24'h0000a8, 6, 1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule